// File: doc/BRIEF.md
# Windowed DMA Channel and Port Register Block

This block is the 32-bit memory-mapped control register file of a multi-channel, multi-port DMA engine. Software does not see a flat map of every channel. It writes a channel number into a select register. After that, a small group of window offsets reaches only that channel's registers: control, poll, descriptor base, descriptor count, interrupt status and interrupt enable. Port control works the same way through a port-select register. A global interrupt-enable register holds one bit per channel.

The block drives the configuration of every channel and port out to the descriptor walkers at the same time. It accepts per-channel event pulses that set sticky status bits, and it raises one interrupt line per channel.

A channel reset, or a reset of the whole engine, runs for a fixed number of cycles and then clears itself. While the reset runs, the channel's on bit and status are held at zero.

Top module: `dma_chan_regfile`

## Requirements
- R1: After reset, every register reads 0 and every output is 0, so the channel select reads 0 and no interrupt is raised.
- R2: Offsets 0x14, 0x1C, 0x20, 0x24, 0x28 and 0x2C reach the channel whose number is in the channel-select register (0x18). Readback is masked as follows:
  - control (0x1C): keeps bits 17:16, 8 and 0;
  - poll (0x14): keeps bits 31 and 6;
  - base (0x20): keeps all 32 bits;
  - count (0x24): keeps bits 15:0;
  - status (0x28) and interrupt enable (0x2C): keep bits 6:1.
- R3: Writing control with bit 1 set starts a channel reset. Bit 1 then reads 1 for exactly RST_CYC (4) cycles and 0 afterwards. The reset clears the on bit and the status at once, and writes to the on bit are ignored while the reset runs.
- R4: Writing 1 to bit 0 of the global control register (0x10) starts the reset on every channel and pulses eng_reset for one cycle. Bit 0 of 0x10 reads 1 while any channel reset runs.
- R5: Event bit j of a channel sets its status bit j+1. Writing 1s to the status register clears those bits. An event in the same cycle as the clear wins, and writing 0x7E clears all status bits.
- R6: Offset 0x44 reaches the port named in the port-select register (0x40). Only bits 11:8, 6, 5:4 and 3:2 are stored, which gives a mask of 0xF7C.
- R7: A channel's ch_irq is 1 exactly when its global enable bit (bit n of 0xF4) is set and some status bit is also set in its interrupt-enable register.
- R8: While the channel or port select is out of range, window reads return 0 and window writes change nothing.
- R9: The per-channel outputs (on, tx, weight, poll enable, divide-by-4, base, count) follow the values written through the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| ch_evt | input | NCH*6 | Event pulses; bit 6n+j sets status bit j+1 of channel n |
| ch_on | output | NCH | Channel enabled |
| ch_tx | output | NCH | Channel direction is transmit |
| ch_weight | output | NCH*2 | Arbitration weight per channel |
| ch_poll_en | output | NCH | Descriptor polling enabled |
| ch_poll_div4 | output | NCH | Poll clock divided by 4 |
| ch_base | output | NCH*32 | Descriptor ring base address |
| ch_count | output | NCH*CNT_W | Descriptor count |
| ch_rst_busy | output | NCH | Channel reset in progress |
| ch_irq | output | NCH | Per-channel interrupt |
| port_ctl | output | NPORT*12 | Stored port control bits |
| eng_reset | output | 1 | One-cycle engine reset pulse |

## Verification
Random sequences mix select changes, including values past the last channel, with window writes and reads of all maskable registers. Comparing each read with a model separates misrouted selects and wrong masks from correct behaviour.

Directed sequences then cover four cases:
- the reset timeline, counted cycle by cycle, with a write to the on bit in the middle of it;
- a clear and an event that hit the same status bit in the same cycle;
- toggling the global enable against a pending status bit;
- out-of-range port and channel writes, checked against snapshots of the outputs.

// File: rtl/dmarf_pkg.sv
// Shared offsets, masks and field types for the windowed DMA register file.
package dmarf_pkg;
    localparam logic [11:0] OFS_GCTL = 12'h010;
    localparam logic [11:0] OFS_POLL = 12'h014;
    localparam logic [11:0] OFS_CSEL = 12'h018;
    localparam logic [11:0] OFS_CCTL = 12'h01C;
    localparam logic [11:0] OFS_BASE = 12'h020;
    localparam logic [11:0] OFS_CNT  = 12'h024;
    localparam logic [11:0] OFS_STAT = 12'h028;
    localparam logic [11:0] OFS_IEN  = 12'h02C;
    localparam logic [11:0] OFS_PSEL = 12'h040;
    localparam logic [11:0] OFS_PCTL = 12'h044;
    localparam logic [11:0] OFS_GIEN = 12'h0F4;

    localparam int EVT_W  = 6;
    localparam int PCTL_W = 12;
    localparam int SEL_W  = 8;
    localparam logic [PCTL_W-1:0] PCTL_MASK = 12'hF7C;

    typedef struct packed {
        logic [1:0] weight;
        logic       tx;
        logic       on;
    } chan_cfg_t;
endpackage

// File: rtl/dmarf_port.sv
// One port's control register.
// Assumes wr_sel is already qualified by the address, the port select and wr_en.
module dmarf_port
    import dmarf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [PCTL_W-1:0] wdata,
    output logic [PCTL_W-1:0] pctl
);
    // Store only the implemented port control bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      pctl <= '0;
        else if (wr_sel) pctl <= wdata & PCTL_MASK;
    end

    assert_port_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> (pctl == ($past(wdata) & PCTL_MASK)));
endmodule

// File: rtl/dmarf_chan.sv
// The register set of one channel: control, poll, base, count, status and enable.
// Assumes wr_sel is already qualified by wr_en and the channel select.
// The address is decoded here.
// A reset started by control bit 1 or by eng_rst lasts RST_CYC cycles.
module dmarf_chan
    import dmarf_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int RST_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [11:0]      addr,
    input  logic [31:0]      wdata,
    input  logic             eng_rst,
    input  logic [EVT_W-1:0] evt,
    output logic [31:0]      rd_word,
    output chan_cfg_t        cfg,
    output logic             poll_en,
    output logic             poll_div4,
    output logic [31:0]      base,
    output logic [CNT_W-1:0] count,
    output logic             irq_raw,
    output logic             busy
);
    localparam int RC_W = $clog2(RST_CYC + 1);

    logic [RC_W-1:0]  rst_cnt;
    logic [EVT_W-1:0] stat, ien, ack;
    logic             wr_ctl, wr_stat, start, clr_now;

    assign wr_ctl  = wr_sel && (addr == OFS_CCTL);
    assign wr_stat = wr_sel && (addr == OFS_STAT);
    assign start   = eng_rst || (wr_ctl && wdata[1]);
    assign busy    = (rst_cnt != '0);
    assign clr_now = busy || start;
    assign ack     = wr_stat ? wdata[EVT_W:1] : '0;
    assign irq_raw = |(stat & ien);

    // Count down the self-clearing reset window.
    always_ff @(posedge clk) begin
        if (!rst_n)     rst_cnt <= '0;
        else if (start) rst_cnt <= RC_W'(RST_CYC);
        else if (busy)  rst_cnt <= rst_cnt - 1'b1;
    end

    // Hold the on bit low while a reset runs; otherwise it follows control writes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_now) cfg.on <= 1'b0;
        else if (wr_ctl)       cfg.on <= wdata[0];
    end

    // Direction, weight and the plain configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.tx     <= 1'b0;
            cfg.weight <= '0;
            poll_en    <= 1'b0;
            poll_div4  <= 1'b0;
            base       <= '0;
            count      <= '0;
            ien        <= '0;
        end else if (wr_sel) begin
            case (addr)
                OFS_CCTL: begin
                    cfg.tx     <= wdata[8];
                    cfg.weight <= wdata[17:16];
                end
                OFS_POLL: begin
                    poll_en   <= wdata[31];
                    poll_div4 <= wdata[6];
                end
                OFS_BASE: base  <= wdata;
                OFS_CNT:  count <= wdata[CNT_W-1:0];
                OFS_IEN:  ien   <= wdata[EVT_W:1];
                default: ;
            endcase
        end
    end

    // Status bits: set by events, cleared by writing ones, zeroed during reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_now) stat <= '0;
        else                   stat <= (stat & ~ack) | evt;
    end

    // Assemble the read word for the addressed window register.
    always_comb begin
        rd_word = '0;
        case (addr)
            OFS_CCTL: rd_word = {14'b0, cfg.weight, 7'b0, cfg.tx, 6'b0, busy, cfg.on};
            OFS_POLL: rd_word = {poll_en, 24'b0, poll_div4, 6'b0};
            OFS_BASE: rd_word = base;
            OFS_CNT:  rd_word = 32'(count);
            OFS_STAT: rd_word = {25'b0, stat, 1'b0};
            OFS_IEN:  rd_word = {25'b0, ien, 1'b0};
            default:  rd_word = '0;
        endcase
    end

    assert_rst_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cnt <= RC_W'(RST_CYC));
    assert_rst_on_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !cfg.on);
    assert_rst_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && (stat == '0)));
    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !clr_now) |=> ((stat & $past(ack & ~evt)) == '0));
endmodule

// File: rtl/dma_chan_regfile.sv
// Top of the windowed DMA register file.
// Holds the channel and port selects, the global interrupt enables and the
// engine reset pulse. Per-channel and per-port registers live in generated
// slots, and the slot named by the select is muxed onto rdata.
// Assumes one access per cycle. Reads have no side effects.
module dma_chan_regfile
    import dmarf_pkg::*;
#(
    parameter int NCH     = 20,
    parameter int NPORT   = 5,
    parameter int CNT_W   = 16,
    parameter int RST_CYC = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [11:0]            addr,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    input  logic [NCH*EVT_W-1:0]   ch_evt,
    output logic [NCH-1:0]         ch_on,
    output logic [NCH-1:0]         ch_tx,
    output logic [NCH*2-1:0]       ch_weight,
    output logic [NCH-1:0]         ch_poll_en,
    output logic [NCH-1:0]         ch_poll_div4,
    output logic [NCH*32-1:0]      ch_base,
    output logic [NCH*CNT_W-1:0]   ch_count,
    output logic [NCH-1:0]         ch_rst_busy,
    output logic [NCH-1:0]         ch_irq,
    output logic [NPORT*PCTL_W-1:0] port_ctl,
    output logic                   eng_reset
);
    logic [SEL_W-1:0] csel, psel;
    logic [NCH-1:0]   gien, irq_raw;
    logic [31:0]      rd_arr [NCH];
    logic [31:0]      ch_rd, pt_rd;
    logic             csel_ok, psel_ok, eng_go;

    assign csel_ok = int'(csel) < NCH;
    assign psel_ok = int'(psel) < NPORT;
    assign eng_go  = wr_en && (addr == OFS_GCTL) && wdata[0];
    assign ch_irq  = gien & irq_raw;

    // Global registers: selects, interrupt enables and the engine reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csel      <= '0;
            psel      <= '0;
            gien      <= '0;
            eng_reset <= 1'b0;
        end else begin
            eng_reset <= eng_go;
            if (wr_en) begin
                case (addr)
                    OFS_CSEL: csel <= wdata[SEL_W-1:0];
                    OFS_PSEL: psel <= wdata[SEL_W-1:0];
                    OFS_GIEN: gien <= wdata[NCH-1:0];
                    default: ;
                endcase
            end
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        chan_cfg_t cfg_g;
        dmarf_chan #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (wr_en && csel_ok && (int'(csel) == g)),
            .addr     (addr),
            .wdata    (wdata),
            .eng_rst  (eng_go),
            .evt      (ch_evt[g*EVT_W +: EVT_W]),
            .rd_word  (rd_arr[g]),
            .cfg      (cfg_g),
            .poll_en  (ch_poll_en[g]),
            .poll_div4(ch_poll_div4[g]),
            .base     (ch_base[g*32 +: 32]),
            .count    (ch_count[g*CNT_W +: CNT_W]),
            .irq_raw  (irq_raw[g]),
            .busy     (ch_rst_busy[g])
        );
        assign ch_on[g]           = cfg_g.on;
        assign ch_tx[g]           = cfg_g.tx;
        assign ch_weight[g*2 +: 2] = cfg_g.weight;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dmarf_port u_port (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_sel(wr_en && (addr == OFS_PCTL) && psel_ok && (int'(psel) == p)),
            .wdata (wdata[PCTL_W-1:0]),
            .pctl  (port_ctl[p*PCTL_W +: PCTL_W])
        );
    end

    // Pick the selected channel's word; zero when the select is out of range.
    always_comb begin
        ch_rd = '0;
        for (int i = 0; i < NCH; i++)
            if (int'(csel) == i) ch_rd = rd_arr[i];
    end

    // Pick the selected port's control bits; zero when out of range.
    always_comb begin
        pt_rd = '0;
        for (int i = 0; i < NPORT; i++)
            if (int'(psel) == i) pt_rd = 32'(port_ctl[i*PCTL_W +: PCTL_W]);
    end

    // Top-level read decode.
    always_comb begin
        case (addr)
            OFS_GCTL: rdata = {31'b0, |ch_rst_busy};
            OFS_CSEL: rdata = 32'(csel);
            OFS_PSEL: rdata = 32'(psel);
            OFS_GIEN: rdata = 32'(gien);
            OFS_PCTL: rdata = pt_rd;
            OFS_POLL, OFS_CCTL, OFS_BASE, OFS_CNT, OFS_STAT, OFS_IEN: rdata = ch_rd;
            default:  rdata = '0;
        endcase
    end

    assert_oor_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!csel_ok && (addr == OFS_BASE)) |-> (rdata == '0));
    assert_oor_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !csel_ok && (addr != OFS_GCTL)) |=> ($stable(ch_base) && $stable(ch_count)));
    assert_gien_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == OFS_GIEN) && (wdata[NCH-1:0] == '0)) |=> (ch_irq == '0));
    assert_eng_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |=> ((&ch_rst_busy) && eng_reset));
endmodule

// File: tb/dma_chan_regfile_test.sv
`timescale 1ns/1ps
module dma_chan_regfile_test;
    localparam int NCH = 20;
    localparam int NPORT = 5;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NCH*6-1:0] ch_evt = '0;
    logic [NCH-1:0] ch_on, ch_tx, ch_poll_en, ch_poll_div4, ch_rst_busy, ch_irq;
    logic [NCH*2-1:0] ch_weight;
    logic [NCH*32-1:0] ch_base;
    logic [NCH*CW-1:0] ch_count;
    logic [NPORT*12-1:0] port_ctl;
    logic eng_reset;

    dma_chan_regfile uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .ch_evt(ch_evt), .ch_on(ch_on), .ch_tx(ch_tx), .ch_weight(ch_weight),
        .ch_poll_en(ch_poll_en), .ch_poll_div4(ch_poll_div4), .ch_base(ch_base),
        .ch_count(ch_count), .ch_rst_busy(ch_rst_busy), .ch_irq(ch_irq),
        .port_ctl(port_ctl), .eng_reset(eng_reset));

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] m_ctl [NCH], m_poll [NCH], m_base [NCH], m_cnt [NCH], m_ien [NCH];
    int m_sel = 0;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    function automatic logic [11:0] win_ofs(input int k);
        case (k)
            0: return 12'h014;
            1: return 12'h01C;
            2: return 12'h020;
            3: return 12'h024;
            default: return 12'h02C;
        endcase
    endfunction

    function automatic logic [31:0] win_mask(input int k);
        case (k)
            0: return 32'h8000_0040;
            1: return 32'h0003_0101;
            2: return 32'hFFFF_FFFF;
            3: return 32'h0000_FFFF;
            default: return 32'h0000_007E;
        endcase
    endfunction

    function automatic logic [31:0] exp_win(input int k);
        if (m_sel >= NCH) return 32'h0;
        case (k)
            0: return m_poll[m_sel];
            1: return m_ctl[m_sel];
            2: return m_base[m_sel];
            3: return m_cnt[m_sel];
            default: return m_ien[m_sel];
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [NCH*32-1:0] snap_base;
        logic [NPORT*12-1:0] snap_port;
        void'($urandom(32'd1234));
        for (int i = 0; i < NCH; i++) begin
            m_ctl[i] = 0; m_poll[i] = 0; m_base[i] = 0; m_cnt[i] = 0; m_ien[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(12'h018, v); chk("R1 csel", v, 0);
        rd(12'h020, v); chk("R1 base", v, 0);
        rd(12'h0F4, v); chk("R1 gien", v, 0);
        chk("R1 irq", 32'(ch_irq), 0);
        chk("R1 on", 32'(ch_on), 0);

        // R2 R8 R9 random window traffic against the model
        for (int it = 0; it < 600; it++) begin
            int op = int'($urandom % 4);
            int k = int'($urandom % 5);
            if (op == 0) begin
                m_sel = int'($urandom % 24);
                wr(12'h018, 32'(m_sel));
            end else if (op == 1) begin
                logic [31:0] d = $urandom;
                if (k == 1) d[1] = 1'b0;
                wr(win_ofs(k), d);
                if (m_sel < NCH) begin
                    case (k)
                        0: m_poll[m_sel] = d & win_mask(k);
                        1: m_ctl[m_sel]  = d & win_mask(k);
                        2: m_base[m_sel] = d;
                        3: m_cnt[m_sel]  = d & win_mask(k);
                        default: m_ien[m_sel] = d & win_mask(k);
                    endcase
                end
            end else begin
                rd(win_ofs(k), v);
                chk(m_sel < NCH ? "R2 window read" : "R8 out-of-range read", v, exp_win(k));
                if (m_sel < NCH) begin
                    chk("R9 base out", ch_base[m_sel*32 +: 32], m_base[m_sel]);
                    chk("R9 count out", 32'(ch_count[m_sel*CW +: CW]), m_cnt[m_sel]);
                    chk("R9 on out", 32'(ch_on[m_sel]), 32'(m_ctl[m_sel][0]));
                    chk("R9 weight out", 32'(ch_weight[m_sel*2 +: 2]), 32'(m_ctl[m_sel][17:16]));
                    chk("R9 poll out", 32'(ch_poll_en[m_sel]), 32'(m_poll[m_sel][31]));
                end
            end
        end

        // R8 directed: out-of-range channel write leaves everything untouched
        snap_base = ch_base;
        wr(12'h018, 32'd30); m_sel = 30;
        wr(12'h020, 32'h1234_5678);
        rd(12'h020, v); chk("R8 oor base read", v, 0);
        chk("R8 oor base unchanged", 32'(ch_base == snap_base), 1);

        // R3 channel reset timeline on channel 5
        wr(12'h018, 32'd5); m_sel = 5;
        wr(12'h01C, 32'h1);
        chk("R9 on set", 32'(ch_on[5]), 1);
        ch_evt[5*6 + 0] = 1'b1;
        @(negedge clk);
        ch_evt = '0;
        rd(12'h028, v); chk("R5 event sets bit1", v, 32'h2);
        wr(12'h01C, 32'h3);
        rd(12'h01C, v); chk("R3 busy reads 1, on cleared", v, 32'h2);
        rd(12'h028, v); chk("R3 status cleared", v, 0);
        wr(12'h01C, 32'h1);
        rd(12'h01C, v); chk("R3 on write ignored while busy", v, 32'h2);
        @(negedge clk);
        rd(12'h01C, v); chk("R3 busy last cycle", v, 32'h2);
        @(negedge clk);
        rd(12'h01C, v); chk("R3 self-cleared", v, 32'h0);
        chk("R3 on output low", 32'(ch_on[5]), 0);

        // R5 R7 status, enables and interrupt on channel 2
        wr(12'h018, 32'd2);
        wr(12'h02C, 32'h08);
        wr(12'h0F4, 32'h4);
        chk("R7 no status no irq", 32'(ch_irq[2]), 0);
        ch_evt[2*6 + 2] = 1'b1;
        @(negedge clk);
        ch_evt = '0;
        rd(12'h028, v); chk("R5 bit3 set", v, 32'h08);
        chk("R7 irq raised", 32'(ch_irq), 32'h4);
        ch_evt[2*6 + 0] = 1'b1;
        @(negedge clk);
        ch_evt = '0;
        rd(12'h028, v); chk("R5 two bits", v, 32'h0A);
        wr(12'h028, 32'h08);
        rd(12'h028, v); chk("R5 w1c bit3", v, 32'h02);
        chk("R7 irq drops with status", 32'(ch_irq[2]), 0);
        @(negedge clk);
        addr = 12'h028; wdata = 32'h02; wr_en = 1'b1; ch_evt[2*6 + 0] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ch_evt = '0;
        rd(12'h028, v); chk("R5 set wins over clear", v, 32'h02);
        ch_evt[2*6 + 2] = 1'b1;
        @(negedge clk);
        ch_evt = '0;
        chk("R7 irq again", 32'(ch_irq[2]), 1);
        wr(12'h0F4, 32'h0);
        chk("R7 global gate", 32'(ch_irq[2]), 0);
        wr(12'h028, 32'h7E);
        rd(12'h028, v); chk("R5 ack all", v, 0);

        // R6 port window
        wr(12'h040, 32'd1);
        wr(12'h044, 32'hFFFF_FFFF);
        rd(12'h044, v); chk("R6 port mask", v, 32'hF7C);
        chk("R6 port out", 32'(port_ctl[12 +: 12]), 32'hF7C);
        wr(12'h040, 32'd0);
        rd(12'h044, v); chk("R6 port0 untouched", v, 0);
        snap_port = port_ctl;
        wr(12'h040, 32'd7);
        wr(12'h044, 32'h0000_0123);
        rd(12'h044, v); chk("R8 oor port read", v, 0);
        chk("R8 oor port write ignored", 32'(port_ctl == snap_port), 1);

        // R4 engine reset
        wr(12'h018, 32'd9);
        wr(12'h01C, 32'h1);
        wr(12'h010, 32'h1);
        rd(12'h010, v); chk("R4 busy flag", v, 1);
        chk("R4 pulse", 32'(eng_reset), 1);
        chk("R4 all channels busy", 32'(ch_rst_busy), 32'h000F_FFFF);
        chk("R4 on cleared", 32'(ch_on), 0);
        @(negedge clk);
        chk("R4 pulse one cycle", 32'(eng_reset), 0);
        @(negedge clk);
        @(negedge clk);
        rd(12'h010, v); chk("R4 still busy", v, 1);
        @(negedge clk);
        rd(12'h010, v); chk("R4 done", v, 0);

        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule